// File: doc/BRIEF.md
# Two-Round SHA-256 Compression Step

This block advances a SHA-256 compression by two rounds in a single operation. It is shaped like one execution unit of a processor. The eight working variables arrive split across two packed 128-bit words. One word carries A, B, E and F. The other carries C, D, G and H. A third 128-bit word supplies, in its low 64 bits, the two round inputs W+K. Each of these is the message word already added to its round constant. The block returns only the new A, B, E and F, packed the same way as the input.

Because the outgoing C, D, G and H after two rounds equal the incoming A, B, E and F, the caller keeps the state moving by hand. The A/B/E/F word it sent becomes the C/D/G/H word of the next request. The word it receives becomes the next A/B/E/F word. The block keeps nothing from one operation to the next.

A valid/ready handshake wraps each operation. With the default setting the result is captured in a single output register. It then waits there until the consumer takes it.

Top module: `sha2r_two_round`

## Requirements
- R1: In `in_abef`, A sits in bits 127:96, B in bits 95:64, E in bits 63:32 and F in bits 31:0.
- R2: In `in_cdgh`, C sits in bits 127:96, D in bits 95:64, G in bits 63:32 and H in bits 31:0.
- R3: The first round consumes `in_wk[31:0]` and the second round consumes `in_wk[63:32]`.
- R4: Bits 127:64 of `in_wk` have no effect on the result.
- R5: Each round works as follows, with every sum taken modulo 2^32.
  - T = Ch(E,F,G) + S1(E) + WK + H.
  - The new A is T + Maj(A,B,C) + S0(A). The new E is T + D.
  - B, C and D take the old A, B and C. F, G and H take the old E, F and G.
  - Ch(e,f,g) = (e&f)^(~e&g) and Maj(a,b,c) = (a&b)^(a&c)^(b&c).
  - S0(a) = ror2^ror13^ror22 and S1(e) = ror6^ror11^ror25.
- R6: `out_abef` carries the state after the second round: A in bits 127:96, B in 95:64, E in 63:32 and F in 31:0.
- R7: The result and `out_valid` appear on the first clock edge after a transfer with both `in_valid` and `in_ready` high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_abef` does not change.
- R9: Synchronous reset clears `out_valid`.
- R10: `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- R11: No state is kept between operations. Chaining with the previous A/B/E/F word as the next C/D/G/H word reproduces consecutive rounds of a full compression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request carries a valid operation |
| in_ready | output | 1 | Block can accept a request this cycle |
| in_cdgh | input | 128 | Packed C, D, G, H working variables |
| in_abef | input | 128 | Packed A, B, E, F working variables |
| in_wk | input | 128 | Two pre-added W+K values in the low 64 bits |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_abef | output | 128 | Packed A, B, E, F after two rounds |

## Verification
The datapath keeps no state between operations, so any wrong internal value shows up in the very result captured on the edge after acceptance. That value can come from a swapped field, a misrouted WK word, a wrong rotation or a dropped carry. It appears at the port one clock after the transfer and is compared against an independent round model. Handshake faults are exposed within a cycle of a stall or drain by the random back-pressure pattern. Examples are a result lost under back-pressure, a valid that does not clear, or a ready that stays low when the register is empty.

// File: rtl/sha2r_pkg.sv
package sha2r_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned STATE_N = 4;
  localparam int unsigned PACK_W  = WORD_W * STATE_N;

  // rotation distances of the two big-sigma functions
  localparam int unsigned S0_R0 = 2;
  localparam int unsigned S0_R1 = 13;
  localparam int unsigned S0_R2 = 22;
  localparam int unsigned S1_R0 = 6;
  localparam int unsigned S1_R1 = 11;
  localparam int unsigned S1_R2 = 25;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } wstate_t;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    word_t r;
    for (int i = 0; i < int'(WORD_W); i++) begin
      r[i] = x[(i + int'(n)) % int'(WORD_W)];
    end
    return r;
  endfunction

  function automatic word_t f_ch(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t f_maj(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic word_t f_bsig0(input word_t x);
    return rotr(x, S0_R0) ^ rotr(x, S0_R1) ^ rotr(x, S0_R2);
  endfunction

  function automatic word_t f_bsig1(input word_t x);
    return rotr(x, S1_R0) ^ rotr(x, S1_R1) ^ rotr(x, S1_R2);
  endfunction

endpackage

// File: rtl/sha2r_round.sv
module sha2r_round
  import sha2r_pkg::*;
(
  input  wstate_t st_i,
  input  word_t   wk_i,
  output wstate_t st_o
);

  word_t t_sum;
  word_t a_mix;

  always_comb begin
    t_sum = f_ch(st_i.e, st_i.f, st_i.g) + f_bsig1(st_i.e) + wk_i + st_i.h;
    a_mix = f_maj(st_i.a, st_i.b, st_i.c) + f_bsig0(st_i.a);
  end

  always_comb begin
    st_o.a = t_sum + a_mix;
    st_o.b = st_i.a;
    st_o.c = st_i.b;
    st_o.d = st_i.c;
    st_o.e = t_sum + st_i.d;
    st_o.f = st_i.e;
    st_o.g = st_i.f;
    st_o.h = st_i.g;
  end

endmodule

// File: rtl/sha2r_core.sv
module sha2r_core
  import sha2r_pkg::*;
#(
  parameter int unsigned ROUNDS = 2,
  localparam int unsigned WK_W  = ROUNDS * WORD_W
) (
  input  logic [PACK_W-1:0] cdgh_i,
  input  logic [PACK_W-1:0] abef_i,
  input  logic [WK_W-1:0]   wk_i,
  output logic [PACK_W-1:0] abef_o
);

  wstate_t chain [ROUNDS+1];

  // unpack the split working state
  always_comb begin
    chain[0].a = abef_i[4*WORD_W-1:3*WORD_W];
    chain[0].b = abef_i[3*WORD_W-1:2*WORD_W];
    chain[0].e = abef_i[2*WORD_W-1:1*WORD_W];
    chain[0].f = abef_i[1*WORD_W-1:0];
    chain[0].c = cdgh_i[4*WORD_W-1:3*WORD_W];
    chain[0].d = cdgh_i[3*WORD_W-1:2*WORD_W];
    chain[0].g = cdgh_i[2*WORD_W-1:1*WORD_W];
    chain[0].h = cdgh_i[1*WORD_W-1:0];
  end

  for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
    sha2r_round u_rnd (
      .st_i (chain[r]),
      .wk_i (wk_i[r*WORD_W +: WORD_W]),
      .st_o (chain[r+1])
    );
  end

  assign abef_o = {chain[ROUNDS].a, chain[ROUNDS].b,
                   chain[ROUNDS].e, chain[ROUNDS].f};

endmodule

// File: rtl/sha2r_two_round.sv
module sha2r_two_round
  import sha2r_pkg::*;
#(
  parameter int unsigned ROUNDS  = 2,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned WK_W   = ROUNDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PACK_W-1:0] in_cdgh,
  input  logic [PACK_W-1:0] in_abef,
  input  logic [PACK_W-1:0] in_wk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PACK_W-1:0] out_abef
);

  logic [PACK_W-1:0] next_abef;

  sha2r_core #(.ROUNDS(ROUNDS)) u_core (
    .cdgh_i (in_cdgh),
    .abef_i (in_abef),
    .wk_i   (in_wk[WK_W-1:0]),
    .abef_o (next_abef)
  );

  if (REG_OUT) begin : g_reg
    logic              hold_vld;
    logic [PACK_W-1:0] hold_dat;
    logic              take;

    assign in_ready = !hold_vld || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        hold_vld <= 1'b0;
      end else if (take) begin
        hold_vld <= 1'b1;
      end else if (out_ready) begin
        hold_vld <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        hold_dat <= next_abef;
      end
    end

    assign out_valid = hold_vld;
    assign out_abef  = hold_dat;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_abef  = next_abef;
  end

endmodule

// File: rtl/sha2r_two_round_chk.sv
module sha2r_two_round_chk #(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned PACK_W  = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PACK_W-1:0] out_abef
);

  if (REG_OUT) begin : g_chk
    // R9: reset empties the result register
    p_rst_clear_r9: assert property (@(posedge clk) rst |=> !out_valid);

    // R7: an accepted request is visible on the next edge
    p_accept_lat_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

    // R8: a stalled result neither disappears nor changes
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_abef)));

    // R10: an empty register never blocks the producer
    p_ready_empty_r10: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

    // R8: valid drops only after a drain
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(out_valid) |-> $past(out_ready));
  end

endmodule

bind sha2r_two_round sha2r_two_round_chk #(
  .REG_OUT (REG_OUT),
  .PACK_W  (sha2r_pkg::PACK_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_abef  (out_abef)
);

// File: tb/test_sha2r_two_round.sv
`timescale 1ns/1ps
module test_sha2r_two_round;

  localparam int CLK_HALF = 10;  // 50 MHz

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_cdgh = '0;
  logic [127:0] in_abef = '0;
  logic [127:0] in_wk = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_abef;

  int total = 0;
  int bad   = 0;
  logic [127:0] exp_q [$];
  string        tag_q [$];
  int  stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [127:0] last_out;

  always #CLK_HALF clk = ~clk;

  sha2r_two_round i_sha2r_two_round (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cdgh(in_cdgh), .in_abef(in_abef), .in_wk(in_wk),
    .out_valid(out_valid), .out_ready(out_ready), .out_abef(out_abef)
  );

  // ---------- independent behavioural model ----------
  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [127:0] model(input logic [127:0] cdgh,
                                         input logic [127:0] abef,
                                         input logic [127:0] wk);
    logic [31:0] a, b, c, d, e, f, g, h, t, k;
    a = abef[127:96]; b = abef[95:64]; e = abef[63:32]; f = abef[31:0];
    c = cdgh[127:96]; d = cdgh[95:64]; g = cdgh[63:32]; h = cdgh[31:0];
    for (int i = 0; i < 2; i++) begin
      k = (i == 0) ? wk[31:0] : wk[63:32];
      t = ((e & f) ^ (~e & g)) + (ror(e,6) ^ ror(e,11) ^ ror(e,25)) + k + h;
      h = g; g = f; f = e; e = d + t;
      d = c;
      t = t + ((a & b) ^ (a & c) ^ (b & c)) + (ror(a,2) ^ ror(a,13) ^ ror(a,22));
      c = b; b = a; a = t;
    end
    return {a, b, e, f};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // ---------- driver ----------
  task automatic send(input logic [127:0] cdgh, input logic [127:0] abef,
                      input logic [127:0] wk, input string tag);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1; in_cdgh = cdgh; in_abef = abef; in_wk = wk;
    exp_q.push_back(model(cdgh, abef, wk));
    tag_q.push_back(tag);
    while (1) begin
      #5 ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // ---------- monitor / scoreboard ----------
  initial begin
    bit prev_stall = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      if (stall_mode != 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0] | lfsr[3];
      end else begin
        out_ready = 1'b1;
      end
      #4;
      if (!rst) begin
        if (prev_stall) begin
          // R8: held result stays valid and unchanged
          check(out_valid && (out_abef == last_out), "R8 hold", out_abef, last_out);
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected result", out_abef, '0);
          end else begin
            string tg;
            logic [127:0] ex;
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(out_abef == ex, tg, out_abef, ex);
          end
        end
        // R10: ready whenever empty or draining
        if (!out_valid || out_ready)
          check(in_ready == 1'b1, "R10 ready", {127'd0, in_ready}, 128'd1);
        prev_stall = out_valid && !out_ready;
        last_out   = out_abef;
      end
    end
  end

  // ---------- watchdog ----------
  initial begin
    #(2 * CLK_HALF * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------- main stimulus ----------
  localparam logic [127:0] ABC_ABEF = {32'h6a09e667, 32'hbb67ae85, 32'h510e527f, 32'h9b05688c};
  localparam logic [127:0] ABC_CDGH = {32'h3c6ef372, 32'ha54ff53a, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [127:0] ABC_WK   = {64'h0, 32'h71374491 + 32'h0, 32'h428a2f98 + 32'h61626380};
  localparam logic [127:0] ABC_EXP  = {32'h5a6ad9ad, 32'h5d6aebcd, 32'h78ce7989, 32'hfa2a4622};

  initial begin
    logic [127:0] ab, cd, nxt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9 reset valid", {127'd0, out_valid}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 idle after reset",
          {126'd0, out_valid, in_ready}, 128'd1);

    // R5 R6 R1 R2 R3: known-answer "abc" first two rounds
    check(model(ABC_CDGH, ABC_ABEF, ABC_WK) == ABC_EXP, "R5 model known answer",
          model(ABC_CDGH, ABC_ABEF, ABC_WK), ABC_EXP);
    send(ABC_CDGH, ABC_ABEF, ABC_WK, "R5 R6 abc rounds 0-1");
    // R7: send returns at the negedge after the accepting edge
    #6 check(out_valid == 1'b1, "R7 latency", {127'd0, out_valid}, 128'd1);
    if (out_valid)
      check(out_abef == ABC_EXP, "R6 abc packing", out_abef, ABC_EXP);
    @(negedge clk);

    // R4: high WK bits ignored
    send(ABC_CDGH, ABC_ABEF, {64'hdeadbeef_f00dcafe, ABC_WK[63:0]}, "R4 wk high ignored");
    send(ABC_CDGH, ABC_ABEF, {64'hffffffff_ffffffff, ABC_WK[63:0]}, "R4 wk high all ones");
    // R3: swapped WK words
    send(ABC_CDGH, ABC_ABEF, {64'h0, ABC_WK[31:0], ABC_WK[63:32]}, "R3 wk order");
    // R1 R2: single-field patterns
    for (int i = 0; i < 4; i++) begin
      send('0, 128'h1 << (32*i + 7), 128'h0, "R1 abef field");
      send(128'h1 << (32*i + 5), '0, 128'h0, "R2 cdgh field");
    end
    // R5: carry wrap with all ones
    send({4{32'hffffffff}}, {4{32'hffffffff}}, {64'h0, {2{32'hffffffff}}}, "R5 modulo wrap");

    // R11: chained rounds of "abc" with random back-pressure
    stall_mode = 1;
    ab = ABC_ABEF; cd = ABC_CDGH;
    for (int r = 0; r < 12; r++) begin
      logic [127:0] wk;
      wk = {64'h0, 32'h9e3779b9 * (2*r+2), 32'h85ebca6b * (2*r+1)};
      send(cd, ab, wk, "R11 chained");
      nxt = model(cd, ab, wk);
      cd = ab; ab = nxt;
    end
    // R8: mixed stream under stalls
    for (int j = 0; j < 40; j++) begin
      send({4{32'h01234567 * j}}, {4{32'h89abcdef ^ j}}, {64'h0, 32'h1000 * j, 32'h77 + j},
           "R8 stream under stall");
    end

    stall_mode = 0;
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule